// File: doc/BRIEF.md
# Segment Blink Gating Controller

This block sits between the display memory of a multiplexed LCD controller and its segment drivers. For every segment of the common currently being scanned, it decides whether the pixel is driven from its memory bit, forced dark, or blanked periodically so that it blinks. The gating is combinational from the memory bits and the current common index. The blink configuration is captured into shadow registers on the frame-start strobe, so software can rewrite it at any time without a partial frame.

Hardware blinking can cover the whole display. It can also be narrowed to at most eight pixels, which sit on segment terminals 0 and 1 across four commons and are picked by two per-common masks. The same frame strobe drives an interval counter that gives a one-cycle frame interrupt once every N+1 frames. Firmware that scrolls or animates the display uses this interrupt as its time base.

Top module: `lcd_blink_ctrl`

## Requirements
- R1: While `seg_en_i` is 0, `seg_o` is all zeros, regardless of every other input and of the blink state.
- R2: While `seg_en_i` is 1 and the active blink enable is 0, `seg_o` equals `mem_i` bit for bit.
- R3: While both enables are active and both active masks are zero, every segment is blanked during the dark half of the blink cycle and shows `mem_i` during the lit half.
- R4: While both enables are active and the combined mask is nonzero, only segment 0 (when bit `com_idx_i` of `mask0_i` is set) and segment 1 (when bit `com_idx_i` of `mask1_i` is set) blink. All other segments follow `mem_i`.
- R5: A segment whose `mem_i` bit is 0 is never driven on.
- R6: `blink_en_i`, `rate_i`, `mask0_i`, `mask1_i` and `ivl_i` take effect only at a cycle where `frame_start_i` is 1. Their new effect is visible from the next cycle. A change between strobes does not alter `seg_o`.
- R7: `rate_i` code k (0..3) gives a half-period of 2^k frames. The frame that enables blinking is lit, and the phase then alternates every 2^k frames.
- R8: With interval N on `ivl_i`, `frame_irq_o` is a one-cycle pulse in the cycle after a strobe, once every N+1 frames. N=0 gives a pulse every frame.
- R9: A strobe that loads a new N raises no interrupt and restarts the count. The first pulse follows the (N+1)-th strobe after it.
- R10: A strobe that loads blink enable 0 resets the phase to lit, so the next enabling starts lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seg_en_i | input | 1 | Global segment enable, immediate |
| blink_en_i | input | 1 | Hardware blink enable, shadowed |
| rate_i | input | 2 | Blink half-period code, shadowed |
| mask0_i | input | 4 | Per-common blink select for segment terminal 0 |
| mask1_i | input | 4 | Per-common blink select for segment terminal 1 |
| ivl_i | input | 5 | Frame interrupt interval N, shadowed |
| frame_start_i | input | 1 | One-cycle frame boundary strobe |
| com_idx_i | input | 2 | Common currently scanned |
| mem_i | input | NUM_SEG | Display memory bits for the current common |
| seg_o | output | NUM_SEG | Gated segment data |
| frame_irq_o | output | 1 | Frame interrupt pulse |

## Verification
The bench builds the block with its defaults: eight segments, four commons, a 2-bit rate code and a 5-bit interval. With eight segments there are terminals beyond 0 and 1, so the bench can show that a nonzero mask leaves them untouched. The short rate codes let the bench reach every half-period, including the eight-frame one, within a few dozen frame strobes. The bench also sweeps interval values across reloads, with N at 0, 3 and 1, and checks the exact frame index of each interrupt.

// File: rtl/lcd_blink_pkg.sv
package lcd_blink_pkg;
  localparam int unsigned NUM_COM  = 4;
  localparam int unsigned COM_W    = $clog2(NUM_COM);
  localparam int unsigned RATE_W   = 2;
  localparam int unsigned MAX_HALF = 1 << ((1 << RATE_W) - 1);
  localparam int unsigned CNT_W    = $clog2(MAX_HALF) + 1;

  typedef struct packed {
    logic                blink_en;
    logic [RATE_W-1:0]   rate;
    logic [NUM_COM-1:0]  mask1;
    logic [NUM_COM-1:0]  mask0;
  } blink_cfg_t;
endpackage

// File: rtl/lcd_blink_cfg.sv
module lcd_blink_cfg
  import lcd_blink_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  blink_cfg_t         cfg_i,
  output logic               blink_act_o,
  output logic [NUM_COM-1:0] mask0_o,
  output logic [NUM_COM-1:0] mask1_o,
  output logic               phase_on_o
);
  logic               blink_q;
  logic [NUM_COM-1:0] mask0_q, mask1_q;
  logic               phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_nxt;
  logic [CNT_W-1:0]   half;

  assign cnt_nxt = cnt_q + CNT_W'(1);
  // rate is consumed only at the strobe, so it needs no shadow copy
  assign half    = CNT_W'(1) << cfg_i.rate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blink_q <= 1'b0;
      mask0_q <= '0;
      mask1_q <= '0;
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (frame_start_i) begin
      blink_q <= cfg_i.blink_en;
      mask0_q <= cfg_i.mask0;
      mask1_q <= cfg_i.mask1;
      if (!cfg_i.blink_en || !blink_q) begin
        phase_q <= 1'b1;
        cnt_q   <= '0;
      end else if (cnt_nxt >= half) begin
        phase_q <= ~phase_q;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_nxt;
      end
    end
  end

  assign blink_act_o = blink_q;
  assign mask0_o     = mask0_q;
  assign mask1_o     = mask1_q;
  assign phase_on_o  = phase_q;
endmodule

// File: rtl/lcd_frame_irq.sv
module lcd_frame_irq #(
  parameter int unsigned IVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             irq_o
);
  logic [IVL_W-1:0] ivl_q;
  logic [IVL_W-1:0] rem_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q <= '0;
      rem_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (frame_start_i) begin
        ivl_q <= ivl_i;
        if (ivl_i != ivl_q) begin
          rem_q <= ivl_i;
        end else if (rem_q == '0) begin
          irq_q <= 1'b1;
          rem_q <= ivl_q;
        end else begin
          rem_q <= rem_q - IVL_W'(1);
        end
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lcd_seg_gate.sv
module lcd_seg_gate
  import lcd_blink_pkg::*;
#(
  parameter int unsigned NUM_SEG = 8
) (
  input  logic               seg_en_i,
  input  logic               blink_act_i,
  input  logic               phase_on_i,
  input  logic [NUM_COM-1:0] mask0_i,
  input  logic [NUM_COM-1:0] mask1_i,
  input  logic [COM_W-1:0]   com_idx_i,
  input  logic [NUM_SEG-1:0] mem_i,
  output logic [NUM_SEG-1:0] seg_o
);
  logic mask_all;
  logic dark;

  assign mask_all = ~|{mask1_i, mask0_i};
  assign dark     = blink_act_i & ~phase_on_i;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic sel;
    if (g == 0) begin : g_t0
      assign sel = mask_all | mask0_i[com_idx_i];
    end else if (g == 1) begin : g_t1
      assign sel = mask_all | mask1_i[com_idx_i];
    end else begin : g_tn
      assign sel = mask_all;
    end
    assign seg_o[g] = seg_en_i & mem_i[g] & ~(sel & dark);
  end
endmodule

// File: rtl/lcd_blink_ctrl.sv
module lcd_blink_ctrl
  import lcd_blink_pkg::*;
#(
  parameter int unsigned NUM_SEG = 8,
  parameter int unsigned IVL_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seg_en_i,
  input  logic               blink_en_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic [NUM_COM-1:0] mask0_i,
  input  logic [NUM_COM-1:0] mask1_i,
  input  logic [IVL_W-1:0]   ivl_i,
  input  logic               frame_start_i,
  input  logic [COM_W-1:0]   com_idx_i,
  input  logic [NUM_SEG-1:0] mem_i,
  output logic [NUM_SEG-1:0] seg_o,
  output logic               frame_irq_o
);
  blink_cfg_t         cfg_in;
  logic               blink_act;
  logic               phase_on;
  logic [NUM_COM-1:0] mask0_act, mask1_act;

  assign cfg_in = '{blink_en: blink_en_i, rate: rate_i, mask1: mask1_i, mask0: mask0_i};

  lcd_blink_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .cfg_i        (cfg_in),
    .blink_act_o  (blink_act),
    .mask0_o      (mask0_act),
    .mask1_o      (mask1_act),
    .phase_on_o   (phase_on)
  );

  lcd_seg_gate #(.NUM_SEG(NUM_SEG)) u_gate (
    .seg_en_i   (seg_en_i),
    .blink_act_i(blink_act),
    .phase_on_i (phase_on),
    .mask0_i    (mask0_act),
    .mask1_i    (mask1_act),
    .com_idx_i  (com_idx_i),
    .mem_i      (mem_i),
    .seg_o      (seg_o)
  );

  lcd_frame_irq #(.IVL_W(IVL_W)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .ivl_i        (ivl_i),
    .irq_o        (frame_irq_o)
  );
endmodule

// File: rtl/lcd_blink_ctrl_chk.sv
module lcd_blink_ctrl_chk #(
  parameter int unsigned NUM_SEG = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               seg_en_i,
  input logic               frame_start_i,
  input logic [NUM_SEG-1:0] mem_i,
  input logic [NUM_SEG-1:0] seg_o,
  input logic               frame_irq_o,
  input logic               blink_act,
  input logic               phase_on,
  input logic               mask_all
);
  assert_seg_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seg_en_i |-> seg_o == '0);
  assert_follow_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_en_i && !blink_act |-> seg_o == mem_i);
  assert_all_dark_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blink_act && mask_all && !phase_on |-> seg_o == '0);
  assert_no_ghost_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o & ~mem_i) == '0);
  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(blink_act));
  assert_phase_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(phase_on));
  assert_irq_after_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_irq_o |-> $past(frame_start_i));
  assert_phase_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blink_act) |-> phase_on);
endmodule

bind lcd_blink_ctrl lcd_blink_ctrl_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .seg_en_i     (seg_en_i),
  .frame_start_i(frame_start_i),
  .mem_i        (mem_i),
  .seg_o        (seg_o),
  .frame_irq_o  (frame_irq_o),
  .blink_act    (blink_act),
  .phase_on     (phase_on),
  .mask_all     (~|{mask1_act, mask0_act})
);

// File: tb/lcd_blink_ctrl_tb_top.sv
`timescale 1ns/1ps
module lcd_blink_ctrl_tb_top;
  localparam int NS = 8;
  localparam int NV = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          seg_en_i = 1'b1;
  logic          blink_en_i = 1'b1;
  logic [1:0]    rate_i = '0;
  logic [3:0]    mask0_i = '0;
  logic [3:0]    mask1_i = '0;
  logic [4:0]    ivl_i = '0;
  logic          frame_start_i = 1'b0;
  logic [1:0]    com_idx_i = '0;
  logic [NS-1:0] mem_i = 8'hFF;
  logic [NS-1:0] seg_o;
  logic          frame_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic irq_s;

  always #10 clk_i = ~clk_i;

  lcd_blink_ctrl dut_i (.*);

  // {seg_en, blink, rate, mask0, mask1, com, mem, frames}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 8'hFF, 4'd2},
    {1'b0, 1'b0, 2'd0, 4'h0, 4'h0, 2'd1, 8'hAA, 4'd1},
    {1'b1, 1'b0, 2'd0, 4'h0, 4'h0, 2'd1, 8'hA5, 4'd1},
    {1'b1, 1'b0, 2'd3, 4'hF, 4'hF, 2'd2, 8'h3C, 4'd2},
    {1'b1, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 8'hFF, 4'd1},
    {1'b1, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 8'hFF, 4'd2},
    {1'b1, 1'b1, 2'd2, 4'h0, 4'h0, 2'd3, 8'h5A, 4'd4},
    {1'b1, 1'b1, 2'd2, 4'h0, 4'h0, 2'd3, 8'h5A, 4'd5},
    {1'b1, 1'b1, 2'd3, 4'h0, 4'h0, 2'd1, 8'hFF, 4'd9},
    {1'b1, 1'b1, 2'd0, 4'h1, 4'h0, 2'd0, 8'hFF, 4'd2},
    {1'b1, 1'b1, 2'd0, 4'h1, 4'h0, 2'd1, 8'hFF, 4'd2},
    {1'b1, 1'b1, 2'd0, 4'h0, 4'h4, 2'd2, 8'hFF, 4'd2},
    {1'b1, 1'b1, 2'd0, 4'h8, 4'h8, 2'd3, 8'hFF, 4'd2},
    {1'b1, 1'b1, 2'd1, 4'h3, 4'h0, 2'd0, 8'hF0, 4'd3}
  };

  function automatic logic [NS-1:0] model(logic en, logic bl, logic [1:0] rt,
      logic [3:0] m0, logic [3:0] m1, logic [1:0] com, logic [NS-1:0] mem, int nfr);
    logic [NS-1:0] r;
    logic lit;
    lit = (((nfr - 1) >> rt) & 1) == 0;   // R7 phase from frames since enable
    r = '0;
    for (int s = 0; s < NS; s++) begin
      logic sel;
      sel = bl && ((m0 == 0 && m1 == 0) || (s == 0 && m0[com]) || (s == 1 && m1[com]));
      r[s] = en && mem[s] && !(sel && !lit);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(output logic irq);
    @(negedge clk_i) frame_start_i = 1'b1;
    @(negedge clk_i) frame_start_i = 1'b0;
    irq = frame_irq_o;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset: blink_en_i already 1 but no strobe yet -> R6, R2
    chk("R2 reset seg", seg_o, 8'hFF);
    chk("R8 reset irq", frame_irq_o, 1'b0);
    chk("R6 no strobe", seg_o, mem_i);

    for (int v = 0; v < NV; v++) begin
      logic [25:0] w;
      string req;
      w = VEC[v];
      blink_en_i = 1'b0;
      frame(irq_s);                     // R10 phase restart
      seg_en_i = w[25]; blink_en_i = w[24]; rate_i = w[23:22];
      mask0_i = w[21:18]; mask1_i = w[17:14];
      for (int f = 0; f < int'(w[3:0]); f++) frame(irq_s);
      com_idx_i = w[13:12]; mem_i = w[11:4];
      #1;
      if (!w[25]) req = "R1";
      else if (!w[24]) req = "R2";
      else if (w[21:14] == 0) req = "R3/R7";
      else req = "R4/R5";
      chk(req, seg_o, model(w[25], w[24], w[23:22], w[21:18], w[17:14],
                            w[13:12], w[11:4], int'(w[3:0])));
    end

    // R6: mask change takes effect only at a strobe
    seg_en_i = 1'b1; blink_en_i = 1'b0; frame(irq_s);
    blink_en_i = 1'b1; rate_i = 2'd1; mask0_i = '0; mask1_i = '0;
    com_idx_i = 2'd0; mem_i = 8'hFF;
    repeat (3) frame(irq_s);
    chk("R3 dark", seg_o, 8'h00);
    mask0_i = 4'h1;
    @(negedge clk_i);
    chk("R6 mask held", seg_o, 8'h00);
    frame(irq_s);
    chk("R6 mask applied R4", seg_o, 8'hFE);
    blink_en_i = 1'b0;
    @(negedge clk_i);
    chk("R6 disable held", seg_o, 8'hFE);
    frame(irq_s);
    chk("R6 disable applied", seg_o, 8'hFF);
    // R10: re-enable starts lit
    blink_en_i = 1'b1; rate_i = 2'd0; mask0_i = '0;
    frame(irq_s);
    chk("R10 lit start", seg_o, 8'hFF);
    frame(irq_s);
    chk("R7 rate0 dark", seg_o, 8'h00);
    mem_i = 8'h00;
    #1 chk("R5 mem zero", seg_o, 8'h00);
    frame(irq_s);
    chk("R5 mem zero lit", seg_o, 8'h00);
    mem_i = 8'h81;
    #1 chk("R5 partial lit", seg_o, 8'h81);
    seg_en_i = 1'b0;
    #1 chk("R1 lit phase", seg_o, 8'h00);
    seg_en_i = 1'b1;

    // R8: N=0 every frame, single-cycle pulse
    ivl_i = 5'd0;
    for (int f = 0; f < 3; f++) begin
      frame(irq_s);
      chk("R8 every frame", irq_s, 1'b1);
    end
    @(negedge clk_i);
    chk("R8 one cycle", frame_irq_o, 1'b0);

    // R9: load N=3, then N=1
    ivl_i = 5'd3;
    for (int f = 0; f < 9; f++) begin
      frame(irq_s);
      chk("R9 N=3", irq_s, (f > 0 && f % 4 == 0));
    end
    ivl_i = 5'd1;
    for (int f = 0; f < 5; f++) begin
      frame(irq_s);
      chk("R9 N=1", irq_s, (f > 0 && f % 2 == 0));
    end

    summary();
  end
endmodule